// File: doc/BRIEF.md
# Two-Tier Rotating Priority Arbiter

This block chooses which of several cores a memory scheduler should serve next. Every core presents two bits: one saying it has a request waiting, and one saying it is stalled on a load and needs attention urgently. The scheduler also supplies the index of the core it is serving now. The arbiter returns a valid flag and the binary index of the winning core. There are no registers in the path, so the result is ready within the same cycle. Latching the result is left to the scheduler.

The search order rotates. The core just after the current one is looked at first, and the current core is looked at last. Two rotating encoders run side by side. One searches the urgent set and the other searches the pending set. Any urgent request wins over every plain pending request. An urgent bit from a core with nothing pending is ignored. A parameter chooses the find-first structure used inside each encoder.

Top module: `arb2_rotating_pick`

## Requirements
- R1: `grant_vld_o` is 1 exactly when at least one bit of `pend_i` is set. While it is 0, `grant_idx_o` is 0.
- R2: A bit of `urgent_i` counts only if the matching bit of `pend_i` is also set. An urgent bit on a core with no pending request has no effect on the output.
- R3: If some core has both its urgent and pending bits set, the granted index is one of those cores.
- R4: If no core has both bits set, the granted index is chosen from the cores whose pending bit is set.
- R5: Within the tier in use, the grant goes to the first eligible core in the order cur+1, cur+2, ..., wrapping modulo NUM_CORES. Core `cur_idx_i` is checked last, so it wins only when it is the sole eligible core.
- R6: When `grant_vld_o` is 1, the `pend_i` bit at `grant_idx_o` is set.
- R7: The outputs depend on the inputs combinationally. A change of input shows at the outputs without any clock edge.
- R8: Bit k of each input vector belongs to core k. `grant_idx_o` is the plain unsigned binary index of the winner. NUM_CORES defaults to 16, and the index width is its ceiling log2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pend_i | input | NUM_CORES | Per-core pending-request bits |
| urgent_i | input | NUM_CORES | Per-core stalled-load (urgent) bits |
| cur_idx_i | input | IDX_W | Index of the core being served now |
| grant_vld_o | output | 1 | At least one core is eligible |
| grant_idx_o | output | IDX_W | Index of the selected core |

## Verification
The assertions are checked on every input change. They cover four things: the valid flag agrees with the pending vector, the granted core really has a request, the urgent tier takes precedence whenever it is non-empty, and no eligible core sits between the current core and the winner in rotating order. The bench scenarios show what a local property cannot pin down on its own. These are the exact winner at the wrap-around points, the masking of urgent bits that have no pending request, the current core winning only when it stands alone, and the absence of any clock dependence.

// File: rtl/arb2_pkg.sv
package arb2_pkg;

   // Ceiling log2 that never returns less than one bit of index.
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // Available find-first structures.
   localparam int FF_LINEAR = 0;
   localparam int FF_ONEHOT = 1;

endpackage

// File: rtl/arb2_rotate.sv
// Rotates a vector so that output bit k is input bit (k + shift) mod N.
module arb2_rotate #(
   parameter int N     = 16,
   parameter int IDX_W = arb2_pkg::idx_width(N)
) (
   input  logic [N-1:0]     vec_i,
   input  logic [IDX_W-1:0] shift_i,
   output logic [N-1:0]     rot_o
);

   always_comb begin
      int src;
      rot_o = '0;
      for (int k = 0; k < N; k++) begin
         src = k + int'(shift_i);
         if (src >= N) src = src - N;
         rot_o[k] = vec_i[src];
      end
   end

endmodule

// File: rtl/arb2_find_first.sv
// Finds the lowest set bit. The structure is chosen by a parameter.
module arb2_find_first #(
   parameter int N       = 16,
   parameter int FF_KIND = arb2_pkg::FF_LINEAR,
   parameter int IDX_W   = arb2_pkg::idx_width(N)
) (
   input  logic [N-1:0]     vec_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);

   if (FF_KIND != arb2_pkg::FF_LINEAR && FF_KIND != arb2_pkg::FF_ONEHOT) begin : g_bad_kind
      $error("arb2_find_first: unsupported FF_KIND %0d", FF_KIND);
   end

   assign any_o = |vec_i;

   if (FF_KIND == arb2_pkg::FF_ONEHOT) begin : g_onehot
      logic [N-1:0] below_any;
      logic [N-1:0] first_hot;

      // Mark the bits that have some set bit beneath them.
      always_comb begin
         logic acc;
         acc = 1'b0;
         for (int k = 0; k < N; k++) begin
            below_any[k] = acc;
            acc = acc | vec_i[k];
         end
      end

      assign first_hot = vec_i & ~below_any;

      // OR together the indices of the hot bits (at most one is set).
      always_comb begin
         idx_o = '0;
         for (int k = 0; k < N; k++) begin
            if (first_hot[k]) idx_o = idx_o | IDX_W'(k);
         end
      end
   end else begin : g_linear
      // Scan from the top down so that the lowest set bit is written last.
      always_comb begin
         idx_o = '0;
         for (int k = N - 1; k >= 0; k--) begin
            if (vec_i[k]) idx_o = IDX_W'(k);
         end
      end
   end

endmodule

// File: rtl/arb2_rot_enc.sv
// Rotating encoder: rotate, find the first set bit, then add the offset back.
module arb2_rot_enc #(
   parameter int N       = 16,
   parameter int FF_KIND = arb2_pkg::FF_LINEAR,
   parameter int IDX_W   = arb2_pkg::idx_width(N)
) (
   input  logic [N-1:0]     vec_i,
   input  logic [IDX_W-1:0] start_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);

   localparam int            SUM_W = IDX_W + 1;
   localparam logic [SUM_W-1:0] N_EXT = SUM_W'(N);

   logic [N-1:0]     rotated;
   logic [IDX_W-1:0] rel_idx;
   logic [SUM_W-1:0] raw_sum;
   logic [SUM_W-1:0] wrapped;

   arb2_rotate #(.N(N), .IDX_W(IDX_W)) u_rot (
      .vec_i   (vec_i),
      .shift_i (start_i),
      .rot_o   (rotated)
   );

   arb2_find_first #(.N(N), .FF_KIND(FF_KIND), .IDX_W(IDX_W)) u_ff (
      .vec_i (rotated),
      .any_o (any_o),
      .idx_o (rel_idx)
   );

   assign raw_sum = {1'b0, rel_idx} + {1'b0, start_i};
   assign wrapped = (raw_sum >= N_EXT) ? (raw_sum - N_EXT) : raw_sum;
   assign idx_o   = wrapped[IDX_W-1:0];

endmodule

// File: rtl/arb2_rotating_pick.sv
module arb2_rotating_pick #(
   parameter int NUM_CORES = 16,
   parameter int FF_KIND   = arb2_pkg::FF_LINEAR,
   parameter int IDX_W     = arb2_pkg::idx_width(NUM_CORES)
) (
   input  logic [NUM_CORES-1:0] pend_i,
   input  logic [NUM_CORES-1:0] urgent_i,
   input  logic [IDX_W-1:0]     cur_idx_i,
   output logic                 grant_vld_o,
   output logic [IDX_W-1:0]     grant_idx_o
);

   localparam int NUM_TIERS = 2;
   localparam int TIER_URG  = 0;
   localparam int TIER_PND  = 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CORES - 1);

   if (NUM_CORES < 2) begin : g_bad_cores
      $error("arb2_rotating_pick: NUM_CORES must be at least 2");
   end
   if (IDX_W < arb2_pkg::idx_width(NUM_CORES)) begin : g_bad_width
      $error("arb2_rotating_pick: IDX_W too narrow for NUM_CORES");
   end

   logic [IDX_W-1:0]     search_start;
   logic [NUM_CORES-1:0] tier_vec [NUM_TIERS];
   logic                 tier_any [NUM_TIERS];
   logic [IDX_W-1:0]     tier_idx [NUM_TIERS];

   // Start searching at the core after the current one. An out-of-range index acts like the last core.
   assign search_start = (cur_idx_i >= LAST_IDX) ? '0 : (cur_idx_i + 1'b1);

   // Urgent bits count only for cores that also have a pending request.
   assign tier_vec[TIER_URG] = urgent_i & pend_i;
   assign tier_vec[TIER_PND] = pend_i;

   for (genvar t = 0; t < NUM_TIERS; t++) begin : g_tier
      arb2_rot_enc #(.N(NUM_CORES), .FF_KIND(FF_KIND), .IDX_W(IDX_W)) u_enc (
         .vec_i   (tier_vec[t]),
         .start_i (search_start),
         .any_o   (tier_any[t]),
         .idx_o   (tier_idx[t])
      );
   end

   always_comb begin
      grant_vld_o = tier_any[TIER_PND];
      if (tier_any[TIER_URG])      grant_idx_o = tier_idx[TIER_URG];
      else if (tier_any[TIER_PND]) grant_idx_o = tier_idx[TIER_PND];
      else                         grant_idx_o = '0;
   end

endmodule

// File: rtl/arb2_rotating_pick_chk.sv
module arb2_rotating_pick_chk #(
   parameter int NUM_CORES = 16,
   parameter int IDX_W     = arb2_pkg::idx_width(NUM_CORES)
) (
   input logic [NUM_CORES-1:0] pend_i,
   input logic [NUM_CORES-1:0] urgent_i,
   input logic [IDX_W-1:0]     cur_idx_i,
   input logic                 grant_vld_o,
   input logic [IDX_W-1:0]     grant_idx_o
);

   logic [NUM_CORES-1:0] elig;
   logic                 skipped_elig;

   // Every eligible core found strictly between the current core and the winner.
   always_comb begin
      int first;
      int pos;
      elig = ((urgent_i & pend_i) != '0) ? (urgent_i & pend_i) : pend_i;
      first = (int'(cur_idx_i) >= NUM_CORES - 1) ? 0 : int'(cur_idx_i) + 1;
      skipped_elig = 1'b0;
      pos = first;
      for (int k = 0; k < NUM_CORES; k++) begin
         if (pos != int'(grant_idx_o) && !skipped_elig && pos < NUM_CORES) begin
            if (elig[pos]) skipped_elig = 1'b1;
         end
         if (pos == int'(grant_idx_o)) pos = NUM_CORES;
         else if (pos < NUM_CORES) pos = (pos == NUM_CORES - 1) ? 0 : pos + 1;
      end
   end

   always_comb begin
      // R1
      vld_matches_pend_chk: assert (grant_vld_o == (pend_i != '0))
         else $error("valid flag disagrees with pending vector");
      // R1
      idle_idx_zero_chk: assert (grant_vld_o || grant_idx_o == '0)
         else $error("index nonzero while invalid");
      // R6
      winner_pending_chk: assert (!grant_vld_o || pend_i[grant_idx_o])
         else $error("granted core has no pending request");
      // R3
      urgent_first_chk: assert (((urgent_i & pend_i) == '0) || urgent_i[grant_idx_o])
         else $error("urgent tier bypassed");
      // R5
      rotation_order_chk: assert (!grant_vld_o || !skipped_elig)
         else $error("eligible core skipped in rotating order");
   end

endmodule

bind arb2_rotating_pick arb2_rotating_pick_chk #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_chk (
   .pend_i      (pend_i),
   .urgent_i    (urgent_i),
   .cur_idx_i   (cur_idx_i),
   .grant_vld_o (grant_vld_o),
   .grant_idx_o (grant_idx_o)
);

// File: tb/arb2_rotating_pick_test.sv
module arb2_rotating_pick_test;

   localparam int  CLK_PERIOD = 10;
   localparam int  N          = 16;
   localparam int  IW         = 4;
   localparam int  NVEC       = 12;
   localparam int  WATCHDOG   = 20000;

   typedef struct packed {
      logic [N-1:0]  pend;
      logic [N-1:0]  urg;
      logic [IW-1:0] cur;
      logic          vld;
      logic [IW-1:0] idx;
   } vec_t;

   // Hand-computed expected results (R1..R5).
   localparam vec_t VECS [NVEC] = '{
      '{16'h0000, 16'h0000, 4'd3,  1'b0, 4'd0 },  // R1 empty
      '{16'h0001, 16'h0000, 4'd0,  1'b1, 4'd0 },  // R5 current core alone
      '{16'h0011, 16'h0000, 4'd0,  1'b1, 4'd4 },  // R4
      '{16'h0011, 16'h0000, 4'd4,  1'b1, 4'd0 },  // R5 wrap
      '{16'h8001, 16'h0000, 4'd15, 1'b1, 4'd0 },  // R5 top wraps to zero
      '{16'h8001, 16'h0000, 4'd14, 1'b1, 4'd15},  // R5
      '{16'h00F0, 16'h0040, 4'd4,  1'b1, 4'd6 },  // R3 urgent beats 5
      '{16'h00B0, 16'h0040, 4'd4,  1'b1, 4'd5 },  // R2 unpending urgent ignored
      '{16'hFFFF, 16'h0101, 4'd8,  1'b1, 4'd0 },  // R3 R5
      '{16'hFFFF, 16'h0101, 4'd0,  1'b1, 4'd8 },  // R3 R5
      '{16'hFFFF, 16'h0000, 4'd7,  1'b1, 4'd8 },  // R4 R8
      '{16'h0000, 16'hFFFF, 4'd2,  1'b0, 4'd0 }   // R1 R2
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [N-1:0]  pend;
   logic [N-1:0]  urg;
   logic [IW-1:0] cur;
   logic          vld;
   logic [IW-1:0] idx;

   int checks   = 0;
   int failures = 0;
   int cycles   = 0;

   arb2_rotating_pick #(.NUM_CORES(N)) uut (
      .pend_i      (pend),
      .urgent_i    (urg),
      .cur_idx_i   (cur),
      .grant_vld_o (vld),
      .grant_idx_o (idx)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles >= WATCHDOG) begin
         failures = failures + 1;
         $display("FAIL watchdog: run hung, got %0d cycles expected < %0d", cycles, WATCHDOG);
         finish_run();
      end
   end

   // Behavioural model written from the requirements.
   function automatic logic [IW:0] model(input logic [N-1:0] p, input logic [N-1:0] u,
                                         input logic [IW-1:0] c);
      logic [N-1:0] set;
      int s;
      set = ((u & p) != '0) ? (u & p) : p;
      if (p == '0) return '0;
      for (int k = 1; k <= N; k++) begin
         s = (int'(c) + k) % N;
         if (set[s]) return {1'b1, IW'(s)};
      end
      return '0;
   endfunction

   task automatic check(input string tag, input logic ev, input logic [IW-1:0] ei);
      checks = checks + 1;
      if (vld !== ev || idx !== ei) begin
         failures = failures + 1;
         $display("FAIL %s: got vld=%0b idx=%0d expected vld=%0b idx=%0d",
                  tag, vld, idx, ev, ei);
      end
   endtask

   task automatic apply(input logic [N-1:0] p, input logic [N-1:0] u, input logic [IW-1:0] c);
      @(negedge clk);
      pend = p;
      urg  = u;
      cur  = c;
      #1;
   endtask

   initial begin
      logic [31:0] lfsr;
      logic [IW:0] exp_r;
      pend = '0;
      urg  = '0;
      cur  = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;

      // Idle inputs (R1).
      apply('0, '0, '0);
      check("R1 idle", 1'b0, '0);

      // Table of hand-computed vectors.
      for (int v = 0; v < NVEC; v++) begin
         apply(VECS[v].pend, VECS[v].urg, VECS[v].cur);
         check($sformatf("R1-5 vector %0d", v), VECS[v].vld, VECS[v].idx);
      end

      // R7: inputs change between clock edges; the outputs follow with no edge.
      @(posedge clk);
      #2;
      pend = 16'h0400; urg = '0; cur = 4'd3;
      #1;
      check("R7 no-edge update", 1'b1, 4'd10);
      urg = 16'h0400; pend = 16'h0500;
      #1;
      check("R7 urgent no-edge", 1'b1, 4'd10);

      // R2: an urgent bit with no pending bit cannot move the winner.
      apply(16'h0008, 16'h0004, 4'd0);
      check("R2 urgent on idle core", 1'b1, 4'd3);

      // R5: two cores next to each other, current is the lower one.
      apply(16'h0006, 16'h0000, 4'd1);
      check("R5 successor wins", 1'b1, 4'd2);
      apply(16'h0006, 16'h0000, 4'd2);
      check("R5 current is last", 1'b1, 4'd1);

      // R6 R3 R4: pseudo-random patterns checked against the model.
      lfsr = 32'hACE1_2468;
      for (int r = 0; r < 300; r++) begin
         logic [N-1:0] p;
         logic [N-1:0] u;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         p = lfsr[15:0] & ((r % 4 == 0) ? lfsr[31:16] : 16'hFFFF);
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         u = lfsr[15:0] & lfsr[31:16] & lfsr[23:8];
         apply(p, u, lfsr[IW-1:0]);
         exp_r = model(p, u, lfsr[IW-1:0]);
         check($sformatf("R3 R4 R6 random %0d", r), exp_r[IW], exp_r[IW-1:0]);
      end

      finish_run();
   end

endmodule